// File: doc/BRIEF.md
# Run-Time Programmable Feed-Forward Gate Array

This block is a small grid of two-input logic cells laid over ordinary fabric. A host loads a circuit into it at run time through two write ports: one fills the per-cell function tables, the other fills the routing selects. A search loop outside the block can therefore try one candidate circuit after another without rebuilding the fabric. Each cell is a 4-to-1 multiplexer. Its data inputs are the four bits of the cell's function table, and its two select lines are the cell's routed operands.

The cells are arranged in columns of `ROWS` cells. A cell may read only the external inputs or cells in earlier columns, so no configuration can create a combinational loop. Each external output may select any external input or any cell. Once loaded, the path from the inputs to the outputs contains no registers. Only the configuration storage is clocked.

Top module: `evo_lattice`

## Requirements
- R1: After reset, every function table and every routing select holds zero. Every cell then drives 0 and every output selects external input 0, so `y_out` equals `x_in[0]` replicated across all outputs.
- R2: A cell's output is bit `{b,a}` of its 4-bit function table, where `a` is its first operand and `b` its second (bit index 2*b + a). For example, 4'b1000 gives AND and 4'b0110 gives XOR.
- R3: Routing entry 2*j selects operand `a` of cell j. Entry 2*j+1 selects operand `b` of cell j. Entry 2*N_LE+k selects output k. A source index s below N_IN means `x_in[s]`; an index s at or above N_IN means the output of cell s-N_IN.
- R4: Cell j belongs to column j/ROWS. Its legal sources are the indices below N_IN + (j/ROWS)*ROWS, which are the external inputs and the cells of earlier columns. An output may use any index below N_IN + N_LE.
- R5: A routing select at or above its legal limit reads `x_in[0]` instead of the source it names.
- R6: When `lut_we` is high on a rising `cfg_clk`, table entry `lut_addr` takes `lut_data`, and the outputs reflect the new value from that edge on. A write with `lut_addr` >= N_LE changes nothing.
- R7: When `rte_we` is high on a rising `cfg_clk`, routing entry `rte_addr` takes `rte_data`, effective from that edge. A write with `rte_addr` >= 2*N_LE+N_OUT changes nothing.
- R8: With both write enables low, the configuration holds across clock edges. `y_out` follows changes on `x_in` with no clock edge between them.
- R9: Loading a conventional two-bit multiplier, with x_in[1:0] as one operand and x_in[3:2] as the other, gives the product on `y_out` for all 16 input rows.
- R10: For random configurations, including out-of-range selects, `y_out` matches an independent model for every input vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock shared by both write ports |
| cfg_rst_n | input | 1 | Asynchronous active-low reset of all configuration |
| lut_we | input | 1 | Function-table write enable |
| lut_addr | input | LAW ($clog2(N_LE)) | Cell index for a table write |
| lut_data | input | 4 | Function table value |
| rte_we | input | 1 | Routing write enable |
| rte_addr | input | RAW ($clog2(2*N_LE+N_OUT)) | Routing entry index |
| rte_data | input | SW ($clog2(N_IN+N_LE)) | Source select value |
| x_in | input | N_IN | External inputs |
| y_out | output | N_OUT | External outputs |

## Verification
A configuration write is due on the `cfg_clk` edge that samples it. The bench drives each write at a falling edge and checks the outputs at the next falling edge, when exactly one rising edge has passed. The outputs are a combinational function of `x_in`, so they are due in the same cycle that `x_in` changes. The bench changes `x_in` on a falling edge and samples 1 ns later, with no rising edge in between. It compares every sample with a model that is updated as each write lands.

// File: rtl/evo_lattice.sv
module evo_lattice #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_LE  = 20,
  parameter int ROWS  = 4,
  localparam int NS   = N_IN + N_LE,
  localparam int N_RT = 2 * N_LE + N_OUT,
  localparam int SW   = $clog2(NS),
  localparam int LAW  = $clog2(N_LE),
  localparam int RAW  = $clog2(N_RT)
) (
  input  logic             cfg_clk,
  input  logic             cfg_rst_n,
  input  logic             lut_we,
  input  logic [LAW-1:0]   lut_addr,
  input  logic [3:0]       lut_data,
  input  logic             rte_we,
  input  logic [RAW-1:0]   rte_addr,
  input  logic [SW-1:0]    rte_data,
  input  logic [N_IN-1:0]  x_in,
  output logic [N_OUT-1:0] y_out
);
  localparam logic [LAW:0] LUT_LIM = (LAW+1)'(N_LE);
  localparam logic [RAW:0] RTE_LIM = (RAW+1)'(N_RT);
  localparam logic [SW:0]  OUT_LIM = (SW+1)'(NS);

  logic [N_LE-1:0][3:0]    lut_q;
  logic [N_RT-1:0][SW-1:0] rte_q;

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      lut_q <= '0;
      rte_q <= '0;
    end else begin
      if (lut_we && ({1'b0, lut_addr} < LUT_LIM)) lut_q[lut_addr] <= lut_data;
      if (rte_we && ({1'b0, rte_addr} < RTE_LIM)) rte_q[rte_addr] <= rte_data;
    end
  end

  // Cells are evaluated in index order, so a cell only sees sources already computed.
  always_comb begin
    logic [NS-1:0] v;
    logic [SW:0]   lim;
    logic [SW-1:0] ia, ib;
    logic          a, b;
    v = '0;
    v[N_IN-1:0] = x_in;
    for (int j = 0; j < N_LE; j++) begin
      lim = (SW+1)'(N_IN + (j / ROWS) * ROWS);
      ia  = rte_q[2*j];
      ib  = rte_q[2*j+1];
      a   = ({1'b0, ia} < lim) ? v[ia] : x_in[0];
      b   = ({1'b0, ib} < lim) ? v[ib] : x_in[0];
      v[N_IN+j] = lut_q[j][{b, a}];
    end
    for (int k = 0; k < N_OUT; k++) begin
      ia       = rte_q[2*N_LE+k];
      y_out[k] = ({1'b0, ia} < OUT_LIM) ? v[ia] : x_in[0];
    end
  end
endmodule

module evo_lattice_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_LE  = 20,
  parameter int ROWS  = 4,
  localparam int NS   = N_IN + N_LE,
  localparam int N_RT = 2 * N_LE + N_OUT,
  localparam int SW   = $clog2(NS),
  localparam int LAW  = $clog2(N_LE),
  localparam int RAW  = $clog2(N_RT)
) (
  input logic                    cfg_clk,
  input logic                    cfg_rst_n,
  input logic                    lut_we,
  input logic [LAW-1:0]          lut_addr,
  input logic [3:0]              lut_data,
  input logic                    rte_we,
  input logic [RAW-1:0]          rte_addr,
  input logic [SW-1:0]           rte_data,
  input logic [N_LE-1:0][3:0]    lut_q,
  input logic [N_RT-1:0][SW-1:0] rte_q
);
  localparam logic [LAW:0] LUT_LIM = (LAW+1)'(N_LE);
  localparam logic [RAW:0] RTE_LIM = (RAW+1)'(N_RT);

  // R6
  lut_write_lands_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    (lut_we && ({1'b0, lut_addr} < LUT_LIM)) |=> lut_q[$past(lut_addr)] == $past(lut_data));

  // R6
  lut_far_write_ignored_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    (!lut_we || ({1'b0, lut_addr} >= LUT_LIM)) |=> $stable(lut_q));

  // R7
  rte_write_lands_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    (rte_we && ({1'b0, rte_addr} < RTE_LIM)) |=> rte_q[$past(rte_addr)] == $past(rte_data));

  // R8
  rte_hold_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    (!rte_we || ({1'b0, rte_addr} >= RTE_LIM)) |=> $stable(rte_q));
endmodule

bind evo_lattice evo_lattice_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_LE(N_LE), .ROWS(ROWS)) u_chk (.*);

// File: tb/tb_evo_lattice.sv
`timescale 1ns/1ps
module tb_evo_lattice;
  localparam int N_IN = 4, N_OUT = 4, N_LE = 20, ROWS = 4;
  localparam int NS = N_IN + N_LE, N_RT = 2 * N_LE + N_OUT;
  localparam int SW = 5, LAW = 5, RAW = 6;

  logic cfg_clk = 0, cfg_rst_n = 0;
  logic lut_we = 0, rte_we = 0;
  logic [LAW-1:0] lut_addr = '0;
  logic [3:0] lut_data = '0;
  logic [RAW-1:0] rte_addr = '0;
  logic [SW-1:0] rte_data = '0;
  logic [N_IN-1:0] x_in = '0;
  logic [N_OUT-1:0] y_out;

  int total = 0, bad = 0, cycles = 0;
  int m_lut[N_LE];
  int m_rte[N_RT];

  evo_lattice dut (.*);

  always #2.5 cfg_clk = ~cfg_clk;

  always @(posedge cfg_clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: got=%0d cycles exp<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x);
    int v[NS];
    logic [N_OUT-1:0] r;
    for (int s = 0; s < NS; s++) v[s] = (s < N_IN) ? int'(x[s]) : 0;
    for (int j = 0; j < N_LE; j++) begin
      int lim = N_IN + (j / ROWS) * ROWS;
      int a = (m_rte[2*j] < lim) ? v[m_rte[2*j]] : int'(x[0]);
      int b = (m_rte[2*j+1] < lim) ? v[m_rte[2*j+1]] : int'(x[0]);
      v[N_IN+j] = (m_lut[j] >> (2*b + a)) & 1;
    end
    for (int k = 0; k < N_OUT; k++) begin
      int s = m_rte[2*N_LE+k];
      r[k] = (s < NS) ? v[s][0] : x[0];
    end
    return r;
  endfunction

  task automatic check(input string rq, input logic [N_OUT-1:0] got, input logic [N_OUT-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s x=%h got=%h exp=%h", rq, x_in, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge cfg_clk) cfg_rst_n = 0;
    lut_we = 0; rte_we = 0;
    for (int j = 0; j < N_LE; j++) m_lut[j] = 0;
    for (int j = 0; j < N_RT; j++) m_rte[j] = 0;
    @(negedge cfg_clk) cfg_rst_n = 1;
  endtask

  task automatic lwr(input int addr, input int data);
    @(negedge cfg_clk);
    lut_we = 1; lut_addr = LAW'(addr); lut_data = 4'(data);
    @(negedge cfg_clk);
    lut_we = 0; lut_data = 4'(~data);
    if (addr < N_LE) m_lut[addr] = data & 15;
  endtask

  task automatic rwr(input int addr, input int data);
    @(negedge cfg_clk);
    rte_we = 1; rte_addr = RAW'(addr); rte_data = SW'(data);
    @(negedge cfg_clk);
    rte_we = 0; rte_data = SW'(~data);
    if (addr < N_RT) m_rte[addr] = data & 31;
  endtask

  task automatic sweep(input string rq);
    for (int x = 0; x < 16; x++) begin
      @(negedge cfg_clk) x_in = 4'(x);
      #1 check(rq, y_out, model(4'(x)));
    end
  endtask

  initial begin
    do_reset();
    // R1: all outputs follow x_in[0]
    for (int x = 0; x < 16; x++) begin
      @(negedge cfg_clk) x_in = 4'(x);
      #1 check("R1", y_out, {N_OUT{x_in[0]}});
    end

    // R2 / R3: cell 0 on x0,x1, output 0 from cell 0, every table value
    rwr(0, 0); rwr(1, 1); rwr(2*N_LE, 4);
    for (int t = 0; t < 16; t++) begin
      lwr(0, t);
      for (int x = 0; x < 4; x++) begin
        @(negedge cfg_clk) x_in = 4'(x);
        #1 check("R2", y_out[0], ((t >> x) & 1) != 0);
        check("R3", y_out, model(x_in));
      end
    end

    // R4 / R5: cell 4 (column 1) on itself is illegal -> x_in[0]; on cell 3 is legal
    do_reset();
    lwr(3, 4'b1111);
    lwr(4, 4'b1010);
    rwr(2*N_LE+1, 8);
    rwr(8, 8);
    for (int x = 0; x < 4; x++) begin
      @(negedge cfg_clk) x_in = 4'(x * 5);
      #1 check("R5", y_out[1], x_in[0]);
    end
    rwr(8, 7);
    for (int x = 0; x < 4; x++) begin
      @(negedge cfg_clk) x_in = 4'(x * 5);
      #1 check("R4", y_out[1], 1'b1);
    end
    rwr(2*N_LE+2, 31);
    for (int x = 0; x < 4; x++) begin
      @(negedge cfg_clk) x_in = 4'(x * 3);
      #1 check("R5", y_out[2], x_in[0]);
    end

    // R9: two-bit multiplier
    do_reset();
    lwr(0, 8); lwr(1, 8); lwr(2, 8); lwr(3, 8);
    lwr(4, 6); lwr(5, 8); lwr(8, 6); lwr(9, 8);
    rwr(0, 0); rwr(1, 2); rwr(2, 1); rwr(3, 2);
    rwr(4, 0); rwr(5, 3); rwr(6, 1); rwr(7, 3);
    rwr(8, 5); rwr(9, 6); rwr(10, 5); rwr(11, 6);
    rwr(16, 7); rwr(17, 9); rwr(18, 7); rwr(19, 9);
    rwr(40, 4); rwr(41, 8); rwr(42, 12); rwr(43, 13);
    for (int x = 0; x < 16; x++) begin
      @(negedge cfg_clk) x_in = 4'(x);
      #1 check("R9", y_out, 4'((x & 3) * (x >> 2)));
    end

    // R6 / R7: out-of-range writes leave the multiplier intact
    lwr(25, 4'b1111); lwr(31, 4'b0110);
    rwr(50, 3); rwr(63, 1);
    for (int x = 0; x < 16; x++) begin
      @(negedge cfg_clk) x_in = 4'(x);
      #1 check("R6", y_out, 4'((x & 3) * (x >> 2)));
    end
    // R7: one in-range write is effective after its edge
    rwr(40, 0);
    sweep("R7");

    // R8: idle cycles with garbage data, enables low
    lut_addr = 0; rte_addr = 40;
    repeat (5) @(negedge cfg_clk);
    sweep("R8");

    // R10: random configurations
    for (int c = 0; c < 20; c++) begin
      for (int j = 0; j < N_LE; j++) lwr(j, int'($urandom_range(0, 15)));
      for (int j = 0; j < N_RT; j++) rwr(j, int'($urandom_range(0, 31)));
      sweep("R10");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule